// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with Serial Scan

This block collects hardware interrupt requests, ranks them by per-source programmable priority and raises a single request line toward the processor that services them. External requests arrive either on five dedicated pins, each of which can be level- or edge-sensitive, or as a serially scanned frame that carries the state of sixteen sources on two pins. Four built-in reload timers act as additional internal sources and produce periodic requests.

Software drives the block through a small register port. Reading the acknowledge location returns the identity of the winning source and marks it in service. Writing the end-of-interrupt location retires the highest-priority source in service. A source interrupts only when its priority is strictly above that of the source currently in service, so handlers nest. When the agent bit is set, the request is steered to an outbound line toward a host instead of the core line.

Source numbering: external sources are 0 to 15, and in direct mode pins 0 to 4 feed sources 0 to 4. Timers are sources 16 to 19. Register map (word addresses): 0 to 19 hold the source configuration, with priority in bits [3:0], mask in bit 4 (1 = masked) and edge-sensitive in bit 5. Address 32 holds the mode register, with bit 0 = serial mode and bit 1 = agent mode. Address 33 is the acknowledge location (read). Address 34 is end-of-interrupt (write, data ignored). Addresses 40 to 43 hold the timer base counts. Read data is combinational in the cycle the read strobe is high.

Top module: `irqc_top`

## Requirements
- R1: After reset, both request lines are low, every configuration register reads 0 and an acknowledge read returns the spurious code 31.
- R2: In direct mode, pin k (k = 0..4) is source k. A level-sensitive source is pending for as long as its pin is high. The request line rises one clock after the pin.
- R3: An edge-sensitive source latches a pending bit on a rising edge of its input. The bit stays set after the input falls and is cleared only when that source is acknowledged.
- R4: In serial mode, a one-cycle high on the sync input starts a frame. The data input is then sampled on the next 16 clocks, source 0 first. All 16 source states update together on the clock of the last bit and hold until the next frame ends. The direct pins are ignored in this mode.
- R5: Among eligible sources, the highest priority value wins, ties go to the lowest source number, and priority 0 disables a source.
- R6: A masked source never causes a request and is never acknowledged, but its edge latch still captures events. Those events are delivered once the source is unmasked.
- R7: An acknowledge read returns the winning source number, marks it in service and clears its edge or timer latch. With no deliverable source, it returns 31 and changes nothing.
- R8: A pending source raises a request only if its priority is strictly greater than the highest priority among sources in service. A source in service is not eligible.
- R9: An end-of-interrupt write takes the in-service mark off only the highest-priority source in service (the lowest number on ties).
- R10: A timer with base count B > 0 expires every B+1 clocks, and the first expiry comes B+1 clocks after the base is written. Each expiry latches a pending bit. Base 0 stops the timer. The base reads back.
- R11: With the agent bit set, a request drives the host line and the core line stays low. With the bit clear, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| directIn | input | 5 | Direct interrupt pins (sources 0..4) |
| serSync | input | 1 | Serial frame start pulse |
| serData | input | 1 | Serial source state bit |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 6 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data |
| coreIrq | output | 1 | Request to the local core |
| hostIrq | output | 1 | Outbound request to the host in agent mode |

## Verification
The hardest situation to reach is nested service: two sources in service at different priorities while a third of equal priority waits. In that state an end-of-interrupt must retire only the higher mark, and the waiting source must stay silent. The bench builds this state by raising pins one at a time and acknowledging between them. It then drops the higher pin and checks the request line after each end-of-interrupt. Serial frames are checked by watching the request line before the last bit of a frame arrives and again after it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int EXT_SRC    = 16;
  localparam int DIRECT_SRC = 5;
  localparam int TIMER_CNT  = 4;
  localparam int NUM_SRC    = EXT_SRC + TIMER_CNT;
  localparam int PRIO_W     = 4;
  localparam int TIMER_W    = 16;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int ID_W       = $clog2(NUM_SRC + 1);
  localparam int SRC_IDX_W  = $clog2(NUM_SRC);
  localparam int TMR_IDX_W  = $clog2(TIMER_CNT);
  localparam logic [ID_W-1:0]   SPURIOUS_ID = '1;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] ADDR_ACK    = ADDR_W'(33);
  localparam logic [ADDR_W-1:0] ADDR_EOI    = ADDR_W'(34);
  localparam logic [ADDR_W-1:0] ADDR_TIMER  = ADDR_W'(40);

  typedef enum logic [2:0] {
    RD_NONE, RD_CFG, RD_MODE, RD_ACK, RD_TIMER
  } rdSel_e;

  typedef struct packed {
    logic                 cfgWr;
    logic [SRC_IDX_W-1:0] cfgIdx;
    logic                 timerWr;
    logic [TMR_IDX_W-1:0] timerIdx;
    logic                 ack;
    logic                 eoi;
    rdSel_e               rdSel;
    logic [DATA_W-1:0]    wrData;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N  = 20,
  parameter int PW = 4,
  parameter int IW = 5
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 found,
  output logic [IW-1:0]        winId,
  output logic [PW-1:0]        winPrio
);
  // Strict greater-than keeps the lowest index on ties; priority 0 never wins.
  always_comb begin
    found   = 1'b0;
    winId   = '0;
    winPrio = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (prio[i] > winPrio)) begin
        found   = 1'b1;
        winId   = IW'(i);
        winPrio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic                  serialMode,
  input  logic [DIRECT_SRC-1:0] directIn,
  input  logic                  serSync,
  input  logic                  serData,
  output logic                  reqValid,
  output logic [DATA_W-1:0]     dpRdData
);
  localparam int BIT_CNT_W = $clog2(EXT_SRC);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(EXT_SRC - 1);

  // configuration
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioVec;
  logic [NUM_SRC-1:0]             maskVec;
  logic [NUM_SRC-1:0]             edgeVec;

  // source capture
  logic [DIRECT_SRC-1:0] directReg;
  logic [EXT_SRC-1:0]    serShift, shiftNext, serState;
  logic                  frameActive, serCommit;
  logic [BIT_CNT_W-1:0]  bitCnt;
  logic [EXT_SRC-1:0]    extRaw, extPrev, edgeLatch, extPend;

  // timers
  logic [TIMER_CNT-1:0][TIMER_W-1:0] tmrBase, tmrCnt;
  logic [TIMER_CNT-1:0]              tmrPend, tmrExpire, tmrLoad;

  // service state
  logic [NUM_SRC-1:0]  inService, pendVec, eligible;
  logic                winFound, isFound, ackTake;
  logic [ID_W-1:0]     winId, isId;
  logic [PRIO_W-1:0]   winPrio, isPrio;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioVec <= '0;
      maskVec <= '0;
      edgeVec <= '0;
    end else if (strobes.cfgWr) begin
      prioVec[strobes.cfgIdx] <= strobes.wrData[PRIO_W-1:0];
      maskVec[strobes.cfgIdx] <= strobes.wrData[PRIO_W];
      edgeVec[strobes.cfgIdx] <= strobes.wrData[PRIO_W+1];
    end
  end

  // serial frame capture: bits land in a shadow, committed together at frame end
  always_comb begin
    shiftNext = serShift;
    if (frameActive && !serSync) shiftNext[bitCnt] = serData;
  end
  assign serCommit = frameActive && !serSync && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      directReg   <= '0;
      serShift    <= '0;
      serState    <= '0;
      frameActive <= 1'b0;
      bitCnt      <= '0;
    end else begin
      directReg <= directIn;
      serShift  <= shiftNext;
      if (serSync) begin
        frameActive <= 1'b1;
        bitCnt      <= '0;
      end else if (frameActive) begin
        bitCnt <= bitCnt + 1'b1;
        if (serCommit) frameActive <= 1'b0;
      end
      if (serCommit) serState <= shiftNext;
    end
  end

  assign extRaw  = serialMode ? serState : EXT_SRC'(directReg);
  assign ackTake = strobes.ack && reqValid;

  generate
    for (genvar e = 0; e < EXT_SRC; e++) begin : g_extPend
      assign extPend[e] = edgeVec[e] ? edgeLatch[e] : extRaw[e];
    end
    for (genvar t = 0; t < TIMER_CNT; t++) begin : g_tmrCtl
      assign tmrLoad[t]   = strobes.timerWr && (strobes.timerIdx == TMR_IDX_W'(t));
      assign tmrExpire[t] = !tmrLoad[t] && (tmrBase[t] != '0) && (tmrCnt[t] == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev   <= '0;
      edgeLatch <= '0;
    end else begin
      extPrev <= extRaw;
      for (int e = 0; e < EXT_SRC; e++) begin
        if (edgeVec[e] && extRaw[e] && !extPrev[e]) edgeLatch[e] <= 1'b1;
        else if (ackTake && (winId == ID_W'(e))) edgeLatch[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrBase <= '0;
      tmrCnt  <= '0;
      tmrPend <= '0;
    end else begin
      for (int t = 0; t < TIMER_CNT; t++) begin
        if (tmrLoad[t]) begin
          tmrBase[t] <= strobes.wrData[TIMER_W-1:0];
          tmrCnt[t]  <= strobes.wrData[TIMER_W-1:0];
        end else if (tmrBase[t] != '0) begin
          tmrCnt[t] <= (tmrCnt[t] == '0) ? tmrBase[t] : tmrCnt[t] - 1'b1;
        end
        if (tmrExpire[t]) tmrPend[t] <= 1'b1;
        else if (ackTake && (winId == ID_W'(EXT_SRC + t))) tmrPend[t] <= 1'b0;
      end
    end
  end

  assign pendVec  = {tmrPend, extPend};
  assign eligible = pendVec & ~maskVec & ~inService;

  irqc_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(ID_W)) u_winArb (
    .valid(eligible), .prio(prioVec),
    .found(winFound), .winId(winId), .winPrio(winPrio)
  );

  irqc_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(ID_W)) u_svcArb (
    .valid(inService), .prio(prioVec),
    .found(isFound), .winId(isId), .winPrio(isPrio)
  );

  assign reqValid = winFound && (winPrio > isPrio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= '0;
    end else begin
      if (ackTake) inService[winId] <= 1'b1;
      if (strobes.eoi && isFound) inService[isId] <= 1'b0;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_CFG:   dpRdData = DATA_W'({edgeVec[strobes.cfgIdx], maskVec[strobes.cfgIdx],
                                    prioVec[strobes.cfgIdx]});
      RD_ACK:   dpRdData = DATA_W'(reqValid ? winId : SPURIOUS_ID);
      RD_TIMER: dpRdData = DATA_W'(tmrBase[strobes.timerIdx]);
      default:  dpRdData = '0;
    endcase
  end

  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |=> inService[$past(winId)]) else $error("ack did not mark source"); // R7
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoi && isFound) |=> !inService[$past(isId)]) else $error("eoi left mark"); // R9
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !serCommit |=> $stable(serState)) else $error("serial state moved mid-frame"); // R4
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !ackTake |=> ((edgeLatch & $past(edgeLatch)) == $past(edgeLatch))) else $error("edge latch lost"); // R3

  generate
    for (genvar t = 0; t < TIMER_CNT; t++) begin : g_tmrChk
      AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        (tmrBase[t] != '0) |-> (tmrCnt[t] <= tmrBase[t])) else $error("timer count above base"); // R10
    end
  endgenerate
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] dpRdData,
  output ctrlStrobes_t      strobes,
  output logic              serialMode,
  output logic [DATA_W-1:0] regRdData,
  output logic              coreIrq,
  output logic              hostIrq
);
  logic              agentMode, modeWr;
  logic [ADDR_W-1:0] tOff;

  assign tOff = regAddr - ADDR_TIMER;

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    strobes.wrData = regWrData;
    modeWr         = 1'b0;
    if (regAddr < ADDR_W'(NUM_SRC)) begin
      strobes.cfgIdx = regAddr[SRC_IDX_W-1:0];
      strobes.cfgWr  = regWrEn;
      if (regRdEn) strobes.rdSel = RD_CFG;
    end else if (regAddr == ADDR_MODE) begin
      modeWr = regWrEn;
      if (regRdEn) strobes.rdSel = RD_MODE;
    end else if (regAddr == ADDR_ACK) begin
      strobes.ack = regRdEn;
      if (regRdEn) strobes.rdSel = RD_ACK;
    end else if (regAddr == ADDR_EOI) begin
      strobes.eoi = regWrEn;
    end else if ((regAddr >= ADDR_TIMER) && (tOff < ADDR_W'(TIMER_CNT))) begin
      strobes.timerIdx = tOff[TMR_IDX_W-1:0];
      strobes.timerWr  = regWrEn;
      if (regRdEn) strobes.rdSel = RD_TIMER;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialMode <= 1'b0;
      agentMode  <= 1'b0;
    end else if (modeWr) begin
      serialMode <= regWrData[0];
      agentMode  <= regWrData[1];
    end
  end

  assign regRdData = (strobes.rdSel == RD_MODE) ? DATA_W'({agentMode, serialMode}) : dpRdData;
  assign coreIrq   = reqValid && !agentMode;
  assign hostIrq   = reqValid && agentMode;

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (agentMode == $past(regWrData[1]))) else $error("agent bit not loaded"); // R11
  AST_AGENT_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (agentMode && $stable(agentMode)) |-> !coreIrq) else $error("core line in agent mode"); // R11
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DIRECT_SRC-1:0] directIn,
  input  logic                  serSync,
  input  logic                  serData,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  coreIrq,
  output logic                  hostIrq
);
  ctrlStrobes_t      strobes;
  logic              serialMode, reqValid;
  logic [DATA_W-1:0] dpRdData;

  irqc_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .reqValid(reqValid),
    .dpRdData(dpRdData), .strobes(strobes), .serialMode(serialMode),
    .regRdData(regRdData), .coreIrq(coreIrq), .hostIrq(hostIrq)
  );

  irqc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serialMode(serialMode),
    .directIn(directIn), .serSync(serSync), .serData(serData),
    .reqValid(reqValid), .dpRdData(dpRdData)
  );
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  directIn = '0;
  logic        serSync = 1'b0, serData = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        coreIrq, hostIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irqc_top u_dut (
    .clk(clk), .rstN(rstN), .directIn(directIn), .serSync(serSync), .serData(serData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .coreIrq(coreIrq), .hostIrq(hostIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regAddr = 6'(addr); regWrData = 16'(data); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    regAddr = 6'(addr); regRdEn = 1'b1;
    #1 data = int'(regRdData);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic ackChk(input string req, input int exp);
    int v;
    rd(33, v);
    chk(req, v, exp);
  endtask

  task automatic eoi();
    wr(34, 0);
  endtask

  task automatic sendFrame(input logic [15:0] bits);
    @(negedge clk); serSync = 1'b1;
    @(negedge clk); serSync = 1'b0; serData = bits[0];
    for (int k = 1; k < 16; k++) begin
      @(negedge clk); serData = bits[k];
    end
    @(negedge clk); serData = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 coreIrq", int'(coreIrq), 0);
    chk("R1 hostIrq", int'(hostIrq), 0);
    rd(0, v);  chk("R1 cfg0", v, 0);
    rd(19, v); chk("R1 cfg19", v, 0);
    ackChk("R1 spurious", 31);

    // R2: each direct pin, level-sensitive
    for (int i = 0; i < 5; i++) begin
      wr(i, 5);
      @(negedge clk); directIn = 5'(1 << i);
      chk("R2 no irq same cycle", int'(coreIrq), 0);
      @(negedge clk);
      chk("R2 irq one clock later", int'(coreIrq), 1);
      ackChk("R2 ack id", i);
      chk("R8 quiet while in service", int'(coreIrq), 0);
      directIn = '0;
      eoi();
      @(negedge clk);
      chk("R2 level drops", int'(coreIrq), 0);
      wr(i, 0);
    end

    // R5: pairwise priority sweep over direct sources
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        if (a != b) begin
          for (int pa = 1; pa <= 3; pa += 2) begin
            for (int pb = 0; pb <= 3; pb++) begin
              int expId;
              if (pb == 2) continue;
              wr(a, pa); wr(b, pb);
              @(negedge clk); directIn = 5'((1 << a) | (1 << b));
              repeat (2) @(negedge clk);
              if (pb == 0) expId = a;
              else if (pa > pb) expId = a;
              else if (pb > pa) expId = b;
              else expId = (a < b) ? a : b;
              ackChk("R5 winner", expId);
              directIn = '0;
              @(negedge clk);
              eoi();
              wr(a, 0); wr(b, 0);
            end
          end
        end
      end
    end

    // R3: edge latch survives pin fall, cleared by ack
    wr(2, 16'h24);
    @(negedge clk); directIn = 5'b00100;
    @(negedge clk); directIn = '0;
    repeat (3) @(negedge clk);
    chk("R3 latched after fall", int'(coreIrq), 1);
    ackChk("R3 ack edge", 2);
    eoi();
    @(negedge clk);
    chk("R3 cleared by ack", int'(coreIrq), 0);
    ackChk("R3 nothing left", 31);
    wr(3, 4);
    @(negedge clk); directIn = 5'b01000;
    @(negedge clk); directIn = '0;
    repeat (2) @(negedge clk);
    chk("R3 level pulse gone", int'(coreIrq), 0);
    wr(2, 0); wr(3, 0);

    // R6: masked edge source latches but does not deliver
    wr(1, 16'h36);
    @(negedge clk); directIn = 5'b00010;
    @(negedge clk); directIn = '0;
    repeat (3) @(negedge clk);
    chk("R6 masked quiet", int'(coreIrq), 0);
    ackChk("R6 masked spurious", 31);
    wr(1, 16'h26);
    @(negedge clk);
    chk("R6 delivered on unmask", int'(coreIrq), 1);
    ackChk("R6 ack after unmask", 1);
    eoi();
    wr(1, 0);

    // R8/R9: nesting
    wr(0, 3); wr(2, 3); wr(4, 7);
    @(negedge clk); directIn = 5'b00001;
    repeat (2) @(negedge clk);
    ackChk("R7 first ack", 0);
    directIn = 5'b00101;
    repeat (2) @(negedge clk);
    chk("R8 equal priority blocked", int'(coreIrq), 0);
    directIn = 5'b10101;
    repeat (2) @(negedge clk);
    chk("R8 higher priority nests", int'(coreIrq), 1);
    ackChk("R8 nested ack", 4);
    directIn = 5'b00101;
    repeat (2) @(negedge clk);
    chk("R8 blocked under two marks", int'(coreIrq), 0);
    eoi();
    @(negedge clk);
    chk("R9 only top mark retired", int'(coreIrq), 0);
    eoi();
    @(negedge clk);
    chk("R9 second eoi reopens", int'(coreIrq), 1);
    ackChk("R5 tie lowest id", 0);
    directIn = '0;
    @(negedge clk);
    eoi();
    wr(0, 0); wr(2, 0); wr(4, 0);
    ackChk("R9 clean", 31);

    // R4: serial mode
    wr(32, 1);
    wr(0, 5);
    @(negedge clk); directIn = 5'h1f;
    repeat (3) @(negedge clk);
    chk("R4 direct pins ignored", int'(coreIrq), 0);
    directIn = '0;
    @(negedge clk); serSync = 1'b1;
    @(negedge clk); serSync = 1'b0; serData = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); serData = 1'b0;
    end
    chk("R4 no update mid-frame", int'(coreIrq), 0);
    for (int k = 9; k <= 15; k++) begin
      @(negedge clk); serData = 1'b0;
    end
    @(negedge clk);
    chk("R4 update at frame end", int'(coreIrq), 1);
    ackChk("R4 source 0 first", 0);
    sendFrame(16'h0000);
    eoi();
    wr(0, 0);
    for (int j = 0; j < 16; j++) begin
      wr(j, (j % 15) + 1);
      sendFrame(16'(1 << j));
      chk("R4 frame bit raises", int'(coreIrq), 1);
      ackChk("R4 frame position", j);
      sendFrame(16'h0000);
      eoi();
      @(negedge clk);
      chk("R4 cleared frame quiet", int'(coreIrq), 0);
      wr(j, 0);
    end
    wr(3, 4); wr(5, 10); wr(9, 10);
    sendFrame(16'h0228);
    ackChk("R5 serial tie", 5);
    sendFrame(16'h0000);
    eoi();
    wr(3, 0); wr(5, 0); wr(9, 0);
    wr(32, 0);

    // R10: timers
    wr(19, 2);
    wr(43, 0);
    repeat (40) @(negedge clk);
    chk("R10 base zero idle", int'(coreIrq), 0);
    wr(19, 0);
    for (int t = 0; t < 4; t++) begin
      int b;
      b = 3 + 2 * t;
      wr(16 + t, 2);
      wr(40 + t, b);
      repeat (b) @(negedge clk);
      chk("R10 not before B+1", int'(coreIrq), 0);
      @(negedge clk);
      chk("R10 expiry at B+1", int'(coreIrq), 1);
      ackChk("R10 timer id", 16 + t);
      chk("R10 latch cleared by ack", int'(coreIrq), 0);
      rd(40 + t, v);
      chk("R10 base readback", v, b);
      wr(16 + t, 0);
      wr(40 + t, 0);
      eoi();
    end
    ackChk("R10 clean", 31);

    // R11: agent mode routing
    wr(32, 2);
    wr(0, 1);
    @(negedge clk); directIn = 5'b00001;
    repeat (2) @(negedge clk);
    chk("R11 host line", int'(hostIrq), 1);
    chk("R11 core line low", int'(coreIrq), 0);
    ackChk("R11 ack", 0);
    directIn = '0;
    @(negedge clk);
    eoi();
    rd(32, v); chk("R11 mode readback", v, 2);
    wr(32, 0);
    wr(0, 1);
    @(negedge clk); directIn = 5'b00001;
    repeat (2) @(negedge clk);
    chk("R11 core line back", int'(coreIrq), 1);
    chk("R11 host line low", int'(hostIrq), 0);
    directIn = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule